// File: doc/BRIEF.md
# Content-Addressed Working Register File

This block keeps the working copies of architectural registers in a pool of physical entries that are found by the register address they hold. The entry index is not decoded from the address. A tag store keeps a 9-bit register address and a valid flag for each of 32 entries. A data store keeps one 64-bit word for each entry, and tag entry i pairs with data entry i. Several read ports and several write ports work at the same time. Their counts, the entry count and the widths are all parameters.

A read is a two-stage pipeline. In the first stage the requested register address is compared against every valid tag, and the matching entry number is registered. In the second stage that entry's word is read, or zero when nothing matched, and presented on registered outputs. A write is also two stages. The producer picks the physical entry and supplies the destination address, which goes into the tag store. On the next cycle the producer supplies the result word, which lands in the same entry. Choosing free entries is left to the surrounding logic. When an address is given to a new entry, any older entry holding that address is retired, so every address lives in at most one entry.

Top module: `cam_wrf`

## Requirements
- R1: While reset is high and in the first cycle after it, every entry is invalid and rd_vld_o, rd_hit_o and rd_data_o are all zero.
- R2: A read request on port r sampled at clock edge k makes rd_vld_o[r] high for exactly the cycle that follows edge k+1. rd_vld_o[r] is never high without such a request.
- R3: If the address sampled at edge k equals the tag of a valid entry, rd_hit_o[r] is 1 and rd_data_o[r] carries that entry's stored word.
- R4: If no valid entry holds the address, rd_hit_o[r] is 0 and rd_data_o[r] is zero. rd_data_o[r] is zero whenever rd_hit_o[r] is 0.
- R5: An allocation on write port w sampled at edge k writes wr_raddr_i[w] into entry wr_entry_i[w] and marks that entry valid. The word on wr_data_i[w] sampled at edge k+1 is stored into that same entry.
- R6: The compare at edge k sees the tag store as it stood before the allocations taken at edge k.
- R7: Allocating an address invalidates every other entry that held the same address.
- R8: If several ports allocate the same address to different entries at one edge, only the entry named by the highest-numbered port stays valid.
- R9: If a data write lands at the read's second edge on the entry that the read matched, the read returns the word being written. When several ports write that entry at one edge, the highest-numbered port's word is stored and returned.
- R10: If several ports allocate the same entry at one edge, the entry takes the address from the highest-numbered port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_alloc_i | input | NWR | Per write port: allocate an entry this cycle |
| wr_entry_i | input | NWR x log2(ENTRIES) | Per write port: physical entry to allocate |
| wr_raddr_i | input | NWR x AW | Per write port: destination register address |
| wr_data_i | input | NWR x DW | Per write port: result word, sampled one cycle after the allocation |
| rd_req_i | input | NRD | Per read port: lookup request |
| rd_raddr_i | input | NRD x AW | Per read port: source register address |
| rd_vld_o | output | NRD | Per read port: result present |
| rd_hit_o | output | NRD | Per read port: address was found |
| rd_data_o | output | NRD x DW | Per read port: read word, zero on a miss |

## Verification
A read sampled at edge k gives its result after edge k+1. An allocation at edge k affects compares from edge k+1 onward, and its word is stored at edge k+1. The bench's reference model follows the same edges: it holds one stage of pending lookups and one stage of pending data writes, and it updates its tag copy only after that edge's compares. Its expected outputs are compared with the ports at every falling edge, between the update edges. Directed sequences put a read and an allocation or data write on the same edge, to cover the compare-before-update rule, the bypass and the port priorities. A long random phase over a narrow address range then forces many re-allocations.

// File: rtl/cam_wrf_pkg.sv
`timescale 1ns/1ps
package cam_wrf_pkg;
  localparam int unsigned WRF_ENTRIES = 32;
  localparam int unsigned WRF_AW      = 9;
  localparam int unsigned WRF_DW      = 64;
  localparam int unsigned WRF_NWR     = 3;
  localparam int unsigned WRF_NRD     = 7;
endpackage

// File: rtl/cam_wrf_tag_cam.sv
`timescale 1ns/1ps
// Tag store plus first read stage: allocation updates and associative compare.
module cam_wrf_tag_cam #(
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned AW      = 9,
  parameter int unsigned NWR     = 3,
  parameter int unsigned NRD     = 7,
  parameter int unsigned IW      = $clog2(ENTRIES)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NWR-1:0]          wr_alloc_i,
  input  logic [NWR-1:0][IW-1:0]  wr_entry_i,
  input  logic [NWR-1:0][AW-1:0]  wr_raddr_i,
  input  logic [NRD-1:0]          rd_req_i,
  input  logic [NRD-1:0][AW-1:0]  rd_raddr_i,
  output logic [NRD-1:0]          m_vld_o,
  output logic [NRD-1:0]          m_hit_o,
  output logic [NRD-1:0][IW-1:0]  m_idx_o
);

  logic [ENTRIES-1:0]         valid_q, valid_n;
  logic [ENTRIES-1:0][AW-1:0] tag_q, tag_n;
  logic [NRD-1:0]             hit_d;
  logic [NRD-1:0][IW-1:0]     idx_d;

  // Next tag-store state: retire old holders, apply allocations (high port wins).
  always_comb begin
    for (int e = 0; e < ENTRIES; e++) begin
      logic          kill;
      logic          set;
      logic          sup;
      logic [AW-1:0] nt;
      int            own;
      kill = 1'b0;
      set  = 1'b0;
      sup  = 1'b0;
      nt   = tag_q[e];
      own  = 0;
      for (int w = 0; w < NWR; w++) begin
        if (wr_alloc_i[w] && valid_q[e] && (tag_q[e] == wr_raddr_i[w]))
          kill = 1'b1;
        if (wr_alloc_i[w] && (wr_entry_i[w] == IW'(e))) begin
          set = 1'b1;
          nt  = wr_raddr_i[w];
          own = w;
        end
      end
      for (int w = 0; w < NWR; w++) begin
        if (set && (w > own) && wr_alloc_i[w] && (wr_raddr_i[w] == nt) &&
            (wr_entry_i[w] != IW'(e)))
          sup = 1'b1;
      end
      valid_n[e] = set ? !sup : (valid_q[e] && !kill);
      tag_n[e]   = nt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      tag_q   <= '0;
    end else begin
      valid_q <= valid_n;
      tag_q   <= tag_n;
    end
  end

  // Associative compare against the pre-update store; lowest entry wins.
  always_comb begin
    for (int r = 0; r < NRD; r++) begin
      hit_d[r] = 1'b0;
      idx_d[r] = '0;
      for (int e = ENTRIES - 1; e >= 0; e--) begin
        if (valid_q[e] && (tag_q[e] == rd_raddr_i[r])) begin
          hit_d[r] = 1'b1;
          idx_d[r] = IW'(e);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      m_vld_o <= '0;
      m_hit_o <= '0;
      m_idx_o <= '0;
    end else begin
      m_vld_o <= rd_req_i;
      m_hit_o <= rd_req_i & hit_d;
      m_idx_o <= idx_d;
    end
  end

endmodule

// File: rtl/cam_wrf_data_ram.sv
`timescale 1ns/1ps
// Data store plus second stages of both pipelines, with write-to-read bypass.
module cam_wrf_data_ram #(
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned DW      = 64,
  parameter int unsigned NWR     = 3,
  parameter int unsigned NRD     = 7,
  parameter int unsigned IW      = $clog2(ENTRIES)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NWR-1:0]          wr_alloc_i,
  input  logic [NWR-1:0][IW-1:0]  wr_entry_i,
  input  logic [NWR-1:0][DW-1:0]  wr_data_i,
  input  logic [NRD-1:0]          m_vld_i,
  input  logic [NRD-1:0]          m_hit_i,
  input  logic [NRD-1:0][IW-1:0]  m_idx_i,
  output logic [NRD-1:0]          rd_vld_o,
  output logic [NRD-1:0]          rd_hit_o,
  output logic [NRD-1:0][DW-1:0]  rd_data_o
);

  logic [DW-1:0]          mem [ENTRIES];
  logic [NWR-1:0]         wq_vld;
  logic [NWR-1:0][IW-1:0] wq_idx;
  logic [NRD-1:0][DW-1:0] rdata_d;

  // Entry index captured at allocation, used for the data write one cycle later.
  always_ff @(posedge clk) begin
    if (rst) begin
      wq_vld <= '0;
      wq_idx <= '0;
    end else begin
      wq_vld <= wr_alloc_i;
      wq_idx <= wr_entry_i;
    end
  end

  // Later ports override earlier ones on the same entry.
  always_ff @(posedge clk) begin
    for (int w = 0; w < NWR; w++) begin
      if (wq_vld[w])
        mem[wq_idx[w]] <= wr_data_i[w];
    end
  end

  always_comb begin
    for (int r = 0; r < NRD; r++) begin
      rdata_d[r] = mem[m_idx_i[r]];
      for (int w = 0; w < NWR; w++) begin
        if (wq_vld[w] && (wq_idx[w] == m_idx_i[r]))
          rdata_d[r] = wr_data_i[w];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_vld_o  <= '0;
      rd_hit_o  <= '0;
      rd_data_o <= '0;
    end else begin
      rd_vld_o <= m_vld_i;
      rd_hit_o <= m_vld_i & m_hit_i;
      for (int r = 0; r < NRD; r++)
        rd_data_o[r] <= (m_vld_i[r] && m_hit_i[r]) ? rdata_d[r] : '0;
    end
  end

endmodule

// File: rtl/cam_wrf.sv
`timescale 1ns/1ps
module cam_wrf
  import cam_wrf_pkg::*;
#(
  parameter int unsigned ENTRIES = WRF_ENTRIES,
  parameter int unsigned AW      = WRF_AW,
  parameter int unsigned DW      = WRF_DW,
  parameter int unsigned NWR     = WRF_NWR,
  parameter int unsigned NRD     = WRF_NRD,
  localparam int unsigned IW     = $clog2(ENTRIES)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NWR-1:0]          wr_alloc_i,
  input  logic [NWR-1:0][IW-1:0]  wr_entry_i,
  input  logic [NWR-1:0][AW-1:0]  wr_raddr_i,
  input  logic [NWR-1:0][DW-1:0]  wr_data_i,
  input  logic [NRD-1:0]          rd_req_i,
  input  logic [NRD-1:0][AW-1:0]  rd_raddr_i,
  output logic [NRD-1:0]          rd_vld_o,
  output logic [NRD-1:0]          rd_hit_o,
  output logic [NRD-1:0][DW-1:0]  rd_data_o
);

  logic [NRD-1:0]         m_vld;
  logic [NRD-1:0]         m_hit;
  logic [NRD-1:0][IW-1:0] m_idx;

  cam_wrf_tag_cam #(
    .ENTRIES(ENTRIES), .AW(AW), .NWR(NWR), .NRD(NRD), .IW(IW)
  ) u_tag (
    .clk       (clk),
    .rst       (rst),
    .wr_alloc_i(wr_alloc_i),
    .wr_entry_i(wr_entry_i),
    .wr_raddr_i(wr_raddr_i),
    .rd_req_i  (rd_req_i),
    .rd_raddr_i(rd_raddr_i),
    .m_vld_o   (m_vld),
    .m_hit_o   (m_hit),
    .m_idx_o   (m_idx)
  );

  cam_wrf_data_ram #(
    .ENTRIES(ENTRIES), .DW(DW), .NWR(NWR), .NRD(NRD), .IW(IW)
  ) u_data (
    .clk       (clk),
    .rst       (rst),
    .wr_alloc_i(wr_alloc_i),
    .wr_entry_i(wr_entry_i),
    .wr_data_i (wr_data_i),
    .m_vld_i   (m_vld),
    .m_hit_i   (m_hit),
    .m_idx_i   (m_idx),
    .rd_vld_o  (rd_vld_o),
    .rd_hit_o  (rd_hit_o),
    .rd_data_o (rd_data_o)
  );

endmodule

// File: rtl/cam_wrf_chk.sv
`timescale 1ns/1ps
module cam_wrf_chk #(
  parameter int unsigned NRD = 7,
  parameter int unsigned DW  = 64
) (
  input logic                   clk,
  input logic                   rst,
  input logic [NRD-1:0]         rd_req_i,
  input logic [NRD-1:0]         rd_vld_o,
  input logic [NRD-1:0]         rd_hit_o,
  input logic [NRD-1:0][DW-1:0] rd_data_o
);

  // R1: outputs quiet in the cycle after reset
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $past(rst) |-> (rd_vld_o == '0 && rd_hit_o == '0));

  for (genvar r = 0; r < NRD; r++) begin : g_port
    // R2: a request yields a result two edges later
    a_r2_vld_follows_req: assert property (@(posedge clk) disable iff (rst)
      rd_req_i[r] |=> ##1 rd_vld_o[r]);
    // R2: no result without a request two edges earlier
    a_r2_vld_needs_req: assert property (@(posedge clk) disable iff (rst)
      rd_vld_o[r] |-> $past(rd_req_i[r], 2));
    // R4: a miss carries zero data
    a_r4_miss_zero: assert property (@(posedge clk) disable iff (rst)
      !rd_hit_o[r] |-> (rd_data_o[r] == '0));
    // R3: a hit only comes with a result
    a_r3_hit_has_vld: assert property (@(posedge clk) disable iff (rst)
      rd_hit_o[r] |-> rd_vld_o[r]);
  end

endmodule

bind cam_wrf cam_wrf_chk #(.NRD(NRD), .DW(DW)) u_cam_wrf_chk (
  .clk      (clk),
  .rst      (rst),
  .rd_req_i (rd_req_i),
  .rd_vld_o (rd_vld_o),
  .rd_hit_o (rd_hit_o),
  .rd_data_o(rd_data_o)
);

// File: tb/cam_wrf_bench.sv
`timescale 1ns/1ps
module cam_wrf_bench;
  import cam_wrf_pkg::*;

  localparam int ENT = WRF_ENTRIES;
  localparam int AW  = WRF_AW;
  localparam int DW  = WRF_DW;
  localparam int NWR = WRF_NWR;
  localparam int NRD = WRF_NRD;
  localparam int IW  = $clog2(ENT);

  logic                   clk = 1'b0;
  logic                   rst = 1'b1;
  logic [NWR-1:0]         wr_alloc_i = '0;
  logic [NWR-1:0][IW-1:0] wr_entry_i = '0;
  logic [NWR-1:0][AW-1:0] wr_raddr_i = '0;
  logic [NWR-1:0][DW-1:0] wr_data_i  = '0;
  logic [NRD-1:0]         rd_req_i   = '0;
  logic [NRD-1:0][AW-1:0] rd_raddr_i = '0;
  logic [NRD-1:0]         rd_vld_o;
  logic [NRD-1:0]         rd_hit_o;
  logic [NRD-1:0][DW-1:0] rd_data_o;

  int    checks = 0;
  int    fails  = 0;
  string phase  = "R3";

  cam_wrf u_cam_wrf (.*);

  always #10 clk = ~clk;

  // Fresh result words every cycle; the model samples them at the data edge.
  always @(negedge clk)
    for (int w = 0; w < NWR; w++) wr_data_i[w] <= {$urandom, $urandom};

  // Reference model state
  bit            mv [ENT];
  logic [AW-1:0] mt [ENT];
  logic [DW-1:0] md [ENT];
  bit            pw_v [NWR];
  int            pw_i [NWR];
  bit            pr_v [NRD];
  bit            pr_h [NRD];
  int            pr_i [NRD];
  bit            ex_v [NRD];
  bit            ex_h [NRD];
  bit            ex_b [NRD];
  logic [DW-1:0] ex_d [NRD];

  always @(posedge clk) begin
    if (rst) begin
      for (int e = 0; e < ENT; e++) begin mv[e] = 0; mt[e] = '0; md[e] = '0; end
      for (int w = 0; w < NWR; w++) pw_v[w] = 0;
      for (int r = 0; r < NRD; r++) begin
        pr_v[r] = 0; ex_v[r] = 0; ex_h[r] = 0; ex_b[r] = 0; ex_d[r] = '0;
      end
    end else begin
      for (int r = 0; r < NRD; r++) begin
        ex_v[r] = pr_v[r];
        ex_h[r] = pr_v[r] && pr_h[r];
        ex_b[r] = 0;
        ex_d[r] = '0;
        if (ex_h[r]) begin
          ex_d[r] = md[pr_i[r]];
          for (int w = 0; w < NWR; w++)
            if (pw_v[w] && pw_i[w] == pr_i[r]) begin ex_d[r] = wr_data_i[w]; ex_b[r] = 1; end
        end
      end
      for (int w = 0; w < NWR; w++)
        if (pw_v[w]) md[pw_i[w]] = wr_data_i[w];
      for (int r = 0; r < NRD; r++) begin
        pr_v[r] = rd_req_i[r];
        pr_h[r] = 0;
        pr_i[r] = 0;
        for (int e = 0; e < ENT; e++)
          if (!pr_h[r] && mv[e] && mt[e] == rd_raddr_i[r]) begin pr_h[r] = 1; pr_i[r] = e; end
      end
      for (int w = 0; w < NWR; w++) begin
        pw_v[w] = wr_alloc_i[w];
        pw_i[w] = int'(wr_entry_i[w]);
        if (wr_alloc_i[w]) begin
          for (int e = 0; e < ENT; e++)
            if (mv[e] && mt[e] == wr_raddr_i[w]) mv[e] = 0;
          mt[pw_i[w]] = wr_raddr_i[w];
          mv[pw_i[w]] = 1;
        end
      end
    end
  end

  task automatic chk(bit ok, string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Compare every port on every falling edge
  always @(negedge clk) begin
    if (!rst) begin
      for (int r = 0; r < NRD; r++) begin
        chk(rd_vld_o[r] == ex_v[r], $sformatf("R2 vld port%0d", r),
            DW'(rd_vld_o[r]), DW'(ex_v[r]));
        chk(rd_hit_o[r] == ex_h[r], $sformatf("%s hit port%0d", phase, r),
            DW'(rd_hit_o[r]), DW'(ex_h[r]));
        chk(rd_data_o[r] == ex_d[r],
            $sformatf("%s data port%0d", ex_b[r] ? "R9" : (!ex_h[r] ? "R4" : phase), r),
            rd_data_o[r], ex_d[r]);
      end
    end
  end

  task automatic clr();
    wr_alloc_i = '0; wr_entry_i = '0; wr_raddr_i = '0;
    rd_req_i = '0; rd_raddr_i = '0;
  endtask
  task automatic alloc(int w, int e, int a);
    wr_alloc_i[w] = 1'b1; wr_entry_i[w] = IW'(e); wr_raddr_i[w] = AW'(a);
  endtask
  task automatic rd(int r, int a);
    rd_req_i[r] = 1'b1; rd_raddr_i[r] = AW'(a);
  endtask
  task automatic nxt();
    @(negedge clk); clr();
  endtask
  task automatic idle(int n);
    repeat (n) nxt();
  endtask

  initial begin
    #(64'd4_000_000);
    fails++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    clr();
    repeat (3) @(negedge clk);
    // R1: outputs zero during reset
    chk(rd_vld_o == '0, "R1 vld", DW'(rd_vld_o), '0);
    chk(rd_hit_o == '0, "R1 hit", DW'(rd_hit_o), '0);
    chk(rd_data_o == '0, "R1 data", rd_data_o[0], '0);
    rst = 1'b0;
    nxt();
    phase = "R5";
    alloc(0, 3, 'h10); alloc(1, 7, 'h20); alloc(2, 31, 'h1ff);
    idle(2);
    rd(0, 'h10); rd(1, 'h20); rd(6, 'h1ff); rd(2, 'h10);
    nxt(); idle(3);
    phase = "R4";
    rd(3, 'h55); rd(4, 'h0);
    nxt(); idle(3);
    phase = "R6";
    alloc(0, 10, 'h77); rd(0, 'h77);
    nxt(); rd(1, 'h77);
    nxt(); idle(3);
    phase = "R7";
    alloc(1, 12, 'h10);
    nxt(); idle(1);
    rd(0, 'h10); rd(5, 'h10);
    nxt(); idle(3);
    phase = "R8";
    alloc(0, 14, 'h88); alloc(2, 15, 'h88);
    nxt(); idle(1);
    rd(0, 'h88);
    nxt(); idle(3);
    phase = "R10";
    alloc(0, 20, 'h91); alloc(1, 20, 'h92);
    nxt(); idle(1);
    rd(0, 'h91); rd(1, 'h92);
    nxt(); idle(3);
    phase = "R9";
    rd(0, 'h20); alloc(0, 7, 'h20);
    nxt();
    rd(1, 'h20); alloc(0, 7, 'h20); alloc(2, 7, 'h20);
    nxt(); idle(3);
    phase = "R2";
    for (int i = 0; i < 6; i++) begin rd(2, (i % 2) ? 'h20 : 'h77); nxt(); end
    idle(3);
    phase = "R3";
    for (int i = 0; i < 3000; i++) begin
      for (int w = 0; w < NWR; w++)
        if ($urandom_range(0, 3) == 0) alloc(w, $urandom_range(0, ENT - 1), $urandom_range(0, 15));
      for (int r = 0; r < NRD; r++)
        if ($urandom_range(0, 1) == 0) rd(r, $urandom_range(0, 15));
      nxt();
    end
    idle(4);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule